// File: doc/BRIEF.md
# Quadrature Tone Synthesizer

This block generates a sine and cosine tone pair at a programmable frequency. A phase accumulator adds a tuning step once per audio sample. The top bits of that phase address a quarter-wave amplitude table, which is folded to cover all four quadrants. Each channel is a 20-bit two's-complement sample. The step is taken from the low 21 bits of a 32-bit tuning word, so the tone frequency is `step * fs / 2^21`, where `fs` is the sample rate.

Two small front-end helpers are built in. The first turns a level-style "codec ready" input into a single-cycle sample enable on its rising edge, one clock late. The second watches the tuning word and reloads the internal step register only in the cycle after the word changes. A one-clock valid pulse marks each new sample pair.

Top module: `qdds_core`

## Requirements
- R1: On each sample enable the phase advances by the step, modulo 2^21. After k samples from reset with a constant step I, the emitted phase is (k*I) mod 2^21.
- R2: Only bits [20:0] of `tune_word` set the step. Two words that differ only in bits [31:21] produce identical output sequences.
- R3: With no sample enable, the phase holds and `sine_out` and `cosine_out` stay unchanged.
- R4: `sine_out` equals round((2^19-1)*sin(2*pi*(q+0.5)/1024)) within 2 LSB. Here q is phase bits [20:11], and the value is read as a signed 20-bit number.
- R5: `cosine_out` follows the R4 formula with q replaced by (q+256) mod 1024, which is the phase plus a quarter turn.
- R6: A new `tune_word` value is captured on the clock edge after it first appears. Every sample enable after that capture uses the new step.
- R7: A low-to-high transition of `codec_ready` produces exactly one sample, however long the level stays high. A falling transition produces no sample.
- R8: `pair_valid` is high for exactly one clock. The `codec_ready` rising edge is driven before clock edge A, and `pair_valid` is high after the fourth edge counting A, and low after the third.
- R9: Synchronous active-low reset clears the phase to zero, the step to zero, both outputs to zero and `pair_valid` to low.
- R10: Neither output ever takes the most negative code 20'h80000. The range is symmetric.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tune_word | input | 32 | Requested phase step; low 21 bits used |
| codec_ready | input | 1 | Level from the audio side; each rise requests one sample |
| sine_out | output | 20 | Sine sample, two's complement |
| cosine_out | output | 20 | Cosine sample, two's complement |
| pair_valid | output | 1 | One-clock pulse when a new sample pair is presented |

## Verification
The assertions assume that `codec_ready` rises no more than once every four clocks, so that valid pulses from successive samples never merge. They also assume that `rst_n` is held low for at least three clocks before the pipeline-history checks start. The bench drives `codec_ready` high for at least five clocks and returns it low for two clocks before the next rise. It changes `tune_word` only between samples, with `codec_ready` low. Reset is held for five clocks.

// File: rtl/qdds_pkg.sv
// Package: shared constants, channel naming and the elaboration-time
// quarter-wave amplitude function used to fill the lookup table.
// Assumes: called only with constant arguments, so it never reaches hardware.
package qdds_pkg;

    localparam real QDDS_PI = 3.14159265358979323846;

    typedef enum int {
        CH_SINE   = 0,
        CH_COSINE = 1
    } qdds_chan_e;

    // Magnitude of entry idx of a quarter-wave table with 2^addr_w entries,
    // sampled at bin centres and scaled to (2^(amp_w-1))-1.
    function automatic int qdds_quarter_mag(input int idx, input int addr_w, input int amp_w);
        real x;
        real term;
        real sum;
        real scale;
        x     = (real'(idx) + 0.5) * QDDS_PI / (2.0 * real'(1 << addr_w));
        term  = x;
        sum   = x;
        for (int k = 1; k <= 9; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        scale = real'((1 << (amp_w - 1)) - 1);
        return int'($rtoi(sum * scale + 0.5));
    endfunction

endpackage

// File: rtl/qdds_rise_pulse.sv
// Module: turns a level input into a registered one-clock pulse on each
// low-to-high transition. Assumes the level is synchronous to clk.
module qdds_rise_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    logic level_d;

    // Remember the previous level and register the rising-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            level_d <= level_i;
            pulse_o <= level_i & ~level_d;
        end
    end
endmodule

// File: rtl/qdds_tune_capture.sv
// Module: compares the requested tuning word with its value one clock
// earlier. On a difference it raises a load strobe and captures the step
// bits into the step register. Assumes reset leaves the previous word at zero.
module qdds_tune_capture #(
    parameter int TUNE_W  = 32,
    parameter int PHASE_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TUNE_W-1:0]  tune_i,
    output logic               load_o,
    output logic [PHASE_W-1:0] step_o
);
    logic [TUNE_W-1:0] tune_prev;

    // Strobe whenever the word differs from last cycle's copy.
    always_comb load_o = (tune_i != tune_prev);

    // Track the previous word and load the step on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tune_prev <= '0;
            step_o    <= '0;
        end else begin
            tune_prev <= tune_i;
            if (load_o) begin
                step_o <= tune_i[PHASE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/qdds_phase_acc.sv
// Module: phase accumulator that wraps modulo 2^PHASE_W and advances by
// the step only when the sample enable is high. It exports only the top
// OUT_W bits, which are the ones the amplitude lookup needs.
module qdds_phase_acc #(
    parameter int PHASE_W = 21,
    parameter int OUT_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic [PHASE_W-1:0] step_i,
    output logic [OUT_W-1:0]   phase_hi_o
);
    logic [PHASE_W-1:0] phase_q;

    // Accumulate one step per enabled sample; the natural width gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (step_en) begin
            phase_q <= phase_q + step_i;
        end
    end

    always_comb phase_hi_o = phase_q[PHASE_W-1 -: OUT_W];
endmodule

// File: rtl/qdds_wave_lookup.sv
// Module: two-stage phase-to-amplitude converter. A shared quarter-wave
// magnitude table is computed at elaboration. Each channel folds its
// quadrant: odd quadrants mirror the address, upper quadrants negate.
// The cosine channel adds one quarter turn to the quadrant.
// Assumes phase_hi carries the quadrant in its top two bits.
module qdds_wave_lookup
    import qdds_pkg::*;
#(
    parameter int LUT_AW = 8,
    parameter int AMP_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LUT_AW+1:0] phase_hi,
    output logic [AMP_W-1:0]  sine_o,
    output logic [AMP_W-1:0]  cosine_o
);
    localparam int DEPTH = 1 << LUT_AW;
    localparam int MAG_W = AMP_W - 1;

    logic [MAG_W-1:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = MAG_W'(qdds_quarter_mag(i, LUT_AW, AMP_W));
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        localparam logic [1:0] QOFF = (ch == int'(CH_COSINE)) ? 2'd1 : 2'd0;
        logic [1:0]        quad;
        logic [LUT_AW-1:0] addr;
        logic [MAG_W-1:0]  mag_q;
        logic              neg_q;
        logic [AMP_W-1:0]  out_q;

        // Rotate the quadrant for this channel and fold the address.
        always_comb begin
            quad = phase_hi[LUT_AW+1:LUT_AW] + QOFF;
            addr = quad[0] ? ~phase_hi[LUT_AW-1:0] : phase_hi[LUT_AW-1:0];
        end

        // Stage 1: table read and sign capture; stage 2: signed output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mag_q <= '0;
                neg_q <= 1'b0;
                out_q <= '0;
            end else begin
                mag_q <= rom[addr];
                neg_q <= quad[1];
                out_q <= neg_q ? -{1'b0, mag_q} : {1'b0, mag_q};
            end
        end
    end

    assign sine_o   = g_chan[0].out_q;
    assign cosine_o = g_chan[1].out_q;
endmodule

// File: rtl/qdds_core.sv
// Module: top of the quadrature tone synthesizer. Connects the ready-edge
// pulse, the tuning capture, the phase accumulator and the amplitude
// lookup, and carries a valid bit down the three-register path.
// Assumes codec_ready rises no more often than once every four clocks.
module qdds_core #(
    parameter int TUNE_W  = 32,
    parameter int PHASE_W = 21,
    parameter int AMP_W   = 20,
    parameter int LUT_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TUNE_W-1:0] tune_word,
    input  logic              codec_ready,
    output logic [AMP_W-1:0]  sine_out,
    output logic [AMP_W-1:0]  cosine_out,
    output logic              pair_valid
);
    localparam int HI_W = LUT_AW + 2;

    logic               samp_en;
    logic               load_stb;
    logic [PHASE_W-1:0] inc_q;
    logic [HI_W-1:0]    phase_hi;
    logic               vld_s1;
    logic               vld_s2;

    qdds_rise_pulse u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (codec_ready),
        .pulse_o (samp_en)
    );

    qdds_tune_capture #(.TUNE_W(TUNE_W), .PHASE_W(PHASE_W)) u_tune (
        .clk    (clk),
        .rst_n  (rst_n),
        .tune_i (tune_word),
        .load_o (load_stb),
        .step_o (inc_q)
    );

    qdds_phase_acc #(.PHASE_W(PHASE_W), .OUT_W(HI_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (samp_en),
        .step_i     (inc_q),
        .phase_hi_o (phase_hi)
    );

    qdds_wave_lookup #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_hi (phase_hi),
        .sine_o   (sine_out),
        .cosine_o (cosine_out)
    );

    // Delay the sample enable to line up with the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_s1     <= 1'b0;
            vld_s2     <= 1'b0;
            pair_valid <= 1'b0;
        end else begin
            vld_s1     <= samp_en;
            vld_s2     <= vld_s1;
            pair_valid <= vld_s2;
        end
    end
endmodule

// File: rtl/qdds_core_checks.sv
// Checker: temporal properties of qdds_core, bound to every instance.
module qdds_core_checks #(
    parameter int TUNE_W  = 32,
    parameter int PHASE_W = 21,
    parameter int AMP_W   = 20,
    parameter int LUT_AW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_en,
    input logic              load_stb,
    input logic [PHASE_W-1:0] inc_q,
    input logic [TUNE_W-1:0] tune_word,
    input logic [LUT_AW+1:0] phase_hi,
    input logic              pair_valid,
    input logic [AMP_W-1:0]  sine_out,
    input logic [AMP_W-1:0]  cosine_out
);
    localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    a_r3_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_en |=> $stable(phase_hi));

    a_r6_inc_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> inc_q == $past(tune_word[PHASE_W-1:0]));

    a_r6_inc_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(inc_q));

    a_r7_enable_single: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en |=> !samp_en);

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    a_r8_valid_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(samp_en, 3));

    a_r10_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sine_out != MOST_NEG) && (cosine_out != MOST_NEG));

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!pair_valid && phase_hi == '0 && sine_out == '0 && cosine_out == '0));
endmodule

bind qdds_core qdds_core_checks #(
    .TUNE_W(TUNE_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W), .LUT_AW(LUT_AW)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_en    (samp_en),
    .load_stb   (load_stb),
    .inc_q      (inc_q),
    .tune_word  (tune_word),
    .phase_hi   (phase_hi),
    .pair_valid (pair_valid),
    .sine_out   (sine_out),
    .cosine_out (cosine_out)
);

// File: tb/qdds_core_bench.sv
module qdds_core_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  PHASE_MASK = (1 << 21) - 1;
    localparam real PI_R       = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tune_word = '0;
    logic        codec_ready = 1'b0;
    logic [19:0] sine_out;
    logic [19:0] cosine_out;
    logic        pair_valid;

    int n_checks = 0;
    int n_errors = 0;
    int exp_phase = 0;
    int cur_step = 0;
    bit done = 1'b0;

    qdds_core u_qdds_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tune_word   (tune_word),
        .codec_ready (codec_ready),
        .sine_out    (sine_out),
        .cosine_out  (cosine_out),
        .pair_valid  (pair_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Ideal amplitude for the 10-bit phase bin q (R4/R5 formula).
    function automatic int ideal_amp(input int q);
        real v;
        v = 524287.0 * $sin(2.0 * PI_R * (real'(q) + 0.5) / 1024.0);
        if (v >= 0.0) return int'($rtoi(v + 0.5));
        return -int'($rtoi(-v + 0.5));
    endfunction

    function automatic bit near(input int a, input int b);
        return (a - b <= 2) && (b - a <= 2);
    endfunction

    task automatic set_tune(input logic [31:0] w);
        @(negedge clk);
        tune_word = w;
        repeat (2) @(posedge clk);
        cur_step = int'(w[20:0]);
    endtask

    // One rising edge of codec_ready; level held for hold extra clocks.
    task automatic take_sample(input int hold);
        int q;
        int s_exp;
        int c_exp;
        logic [19:0] s_now;
        logic [19:0] c_now;
        @(negedge clk);
        codec_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 check(pair_valid == 1'b0, "R8 early", pair_valid, 0);
        @(posedge clk);
        #1 check(pair_valid == 1'b1, "R8 valid", pair_valid, 1);
        exp_phase = (exp_phase + cur_step) & PHASE_MASK;
        q     = exp_phase >> 11;
        s_exp = ideal_amp(q);
        c_exp = ideal_amp((q + 256) & 1023);
        check(near(int'($signed(sine_out)), s_exp), "R1 R4 sine", int'($signed(sine_out)), s_exp);
        check(near(int'($signed(cosine_out)), c_exp), "R5 cosine", int'($signed(cosine_out)), c_exp);
        check(sine_out != 20'h80000 && cosine_out != 20'h80000, "R10 range", sine_out, 0);
        s_now = sine_out;
        c_now = cosine_out;
        for (int i = 0; i <= hold; i++) begin
            @(posedge clk);
            #1 check(pair_valid == 1'b0, "R7 R8 single", pair_valid, 0);
        end
        @(negedge clk);
        codec_ready = 1'b0;
        repeat (2) @(posedge clk);
        #1 check(pair_valid == 1'b0, "R7 fall", pair_valid, 0);
        check(sine_out == s_now && cosine_out == c_now, "R3 hold", sine_out, s_now);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 check(pair_valid == 1'b0, "R9 valid", pair_valid, 0);
        check(sine_out == '0 && cosine_out == '0, "R9 outputs", sine_out, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: first sample from zero phase lands on the step itself.
        set_tune(32'h0000_3F17);
        take_sample(1);

        // R4/R5: one table bin per sample visits every bin of both channels.
        exp_phase = 0;
        @(negedge clk);
        rst_n = 1'b0;
        tune_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        set_tune(32'h0000_0800);
        for (int k = 0; k < 1024; k++) take_sample(0);

        // R2: upper bits set, same low step; sequence continues unchanged.
        set_tune(32'hFFE0_0800);
        for (int k = 0; k < 16; k++) take_sample(0);

        // R7/R3: long high level gives a single sample, outputs hold.
        take_sample(12);

        // R6/R1: new odd step applied from the next sample, with wrap.
        set_tune(32'h0001_ABCD);
        for (int k = 0; k < 200; k++) take_sample(0);
        set_tune(32'h001F_F001);
        for (int k = 0; k < 40; k++) take_sample(1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule